// File: doc/BRIEF.md
# Trap Entry and Return Privilege State Unit

This block keeps the hart's current privilege level and the interrupt-enable stack of the status register. When a trap is taken, it records the faulting PC, the cause and the trap value in the register set of the level that handles the trap. When a machine, supervisor or user return executes, it unwinds the enable stack and the privilege level.

A synchronous exception is routed to a level through two delegation masks. The block then raises this level if needed so that a trap never lowers the privilege. Interrupt requests are always handled in machine mode. Each trap or return also sends a one-cycle pulse that cancels any load-reserved reservation. Each trap emits a handler-select pulse that names the level whose vector the fetch unit should use.

All state is registered. A strobe presented in one cycle is visible at the outputs after the next rising clock edge.

Top module: `trap_ctl_top`

## Requirements
- R1: After synchronous reset the privilege is machine. The privilege encoding is user=0, supervisor=1, machine=3. The status output, all nine epc/cause/tval outputs, `rsv_cancel` and `vec_go` are zero, and `vec_level` reads machine.
- R2: An exception (trap_irq=0) with code c has a raw target as follows. It is user when has_u=1 and it qualifies for user: when has_s=1 that needs exc_deleg_m[c], has_n and exc_deleg_s[c] all set, and when has_s=0 it needs exc_deleg_m[c] and has_n. Otherwise the target is supervisor when has_s=1 and exc_deleg_m[c]=1. Otherwise it is machine. An interrupt (trap_irq=1) always targets machine.
- R3: If the raw target encoding is below the current privilege, the trap is handled at the current privilege.
- R4: The status output uses these bits: UIE 0, SIE 1, MIE 3, UPIE 4, SPIE 5, MPIE 7, SPP 8, MPP 12:11, with all other bits zero. A machine-level trap does the following. MPIE takes the old MIE and MIE clears. MPP takes the old privilege. m_epc takes trap_pc. m_tval takes trap_val when trap_val_ok=1, else zero. m_cause has bit XLEN-1 equal to trap_irq, the code in its low CODE_W bits, and zeros in between.
- R5: A supervisor-level trap copies SIE into SPIE and clears SIE. It sets SPP to 1 when coming from supervisor and to 0 when coming from user. It writes s_epc, s_cause and s_tval in the R4 format.
- R6: A user-level trap copies UIE into UPIE and clears UIE. It writes u_epc, u_cause and u_tval in the R4 format.
- R7: A machine return copies MPIE into MIE and sets MPIE. It moves the privilege to the old MPP. It then sets MPP to user when has_u=1 and to machine otherwise.
- R8: A supervisor return copies SPIE into SIE and sets SPIE. It moves to supervisor when SPP=1 and to user otherwise, then clears SPP.
- R9: A user return copies UPIE into UIE, sets UPIE and moves to user.
- R10: `rsv_cancel` is high for exactly the cycle after a cycle in which any trap or return strobe was high, and low otherwise.
- R11: A trap request wins over return strobes in the same cycle. Among returns, machine wins over supervisor, which wins over user. Losing strobes have no effect.
- R12: `vec_go` pulses in the cycle after a trap request. `vec_level` then shows the handling level and holds it until the next trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | Take a trap this cycle |
| trap_irq | input | 1 | Trap is an interrupt |
| trap_code | input | CODE_W | Cause code |
| trap_pc | input | XLEN | PC of the trapping instruction |
| trap_val | input | XLEN | Trap value |
| trap_val_ok | input | 1 | trap_val is meaningful |
| exc_deleg_m | input | 2**CODE_W | Exceptions passed down from machine |
| exc_deleg_s | input | 2**CODE_W | Exceptions passed down from supervisor |
| ret_m | input | 1 | Machine return |
| ret_s | input | 1 | Supervisor return |
| ret_u | input | 1 | User return |
| has_s | input | 1 | Supervisor mode implemented |
| has_u | input | 1 | User mode implemented |
| has_n | input | 1 | User-level traps implemented |
| cur_priv | output | 2 | Current privilege |
| status | output | XLEN | Status register view |
| m_epc | output | XLEN | Machine exception PC |
| m_cause | output | XLEN | Machine cause |
| m_tval | output | XLEN | Machine trap value |
| s_epc | output | XLEN | Supervisor exception PC |
| s_cause | output | XLEN | Supervisor cause |
| s_tval | output | XLEN | Supervisor trap value |
| u_epc | output | XLEN | User exception PC |
| u_cause | output | XLEN | User cause |
| u_tval | output | XLEN | User trap value |
| rsv_cancel | output | 1 | Reservation cancel pulse |
| vec_go | output | 1 | Trap handler fetch pulse |
| vec_level | output | 2 | Level whose handler to fetch |

## Verification
A corrupted enable-stack bit stays hidden until a return pops it. It then shows on `status` one cycle after that return, and often several operations after the fault. For this reason the bench runs long mixed sequences of traps and returns against a reference model. A wrong privilege shows on `cur_priv` and on the next trap's `vec_level` and saved-privilege fields one cycle after the strobe. Delegation and clamp errors show in which epc/cause/tval set gets written.

// File: rtl/trap_ctl_pkg.sv
`timescale 1ns/1ps
package trap_ctl_pkg;

    typedef enum logic [1:0] {
        PRV_U = 2'b00,
        PRV_S = 2'b01,
        PRV_M = 2'b11
    } priv_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_TRAP,
        OP_MRET,
        OP_SRET,
        OP_URET
    } op_e;

    localparam int ST_UIE  = 0;
    localparam int ST_SIE  = 1;
    localparam int ST_MIE  = 3;
    localparam int ST_UPIE = 4;
    localparam int ST_SPIE = 5;
    localparam int ST_MPIE = 7;
    localparam int ST_SPP  = 8;
    localparam int ST_MPP  = 11;
    localparam int ST_W    = 13;

    typedef struct packed {
        logic  uie;
        logic  sie;
        logic  mie;
        logic  upie;
        logic  spie;
        logic  mpie;
        logic  spp;
        priv_e mpp;
    } stat_t;

    function automatic logic [ST_W-1:0] pack_status(stat_t s);
        logic [ST_W-1:0] v;
        v = '0;
        v[ST_UIE]        = s.uie;
        v[ST_SIE]        = s.sie;
        v[ST_MIE]        = s.mie;
        v[ST_UPIE]       = s.upie;
        v[ST_SPIE]       = s.spie;
        v[ST_MPIE]       = s.mpie;
        v[ST_SPP]        = s.spp;
        v[ST_MPP+1:ST_MPP] = s.mpp;
        return v;
    endfunction

    // Register-set index: 0 user, 1 supervisor, 2 machine
    function automatic int lvl_idx(priv_e p);
        case (p)
            PRV_U:   return 0;
            PRV_S:   return 1;
            default: return 2;
        endcase
    endfunction

endpackage

// File: rtl/trap_deleg.sv
`timescale 1ns/1ps
module trap_deleg
    import trap_ctl_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic                     irq,
    input  logic [CODE_W-1:0]        code,
    input  logic [(1<<CODE_W)-1:0]   deleg_m,
    input  logic [(1<<CODE_W)-1:0]   deleg_s,
    input  logic                     has_s,
    input  logic                     has_u,
    input  logic                     has_n,
    input  priv_e                    cur,
    output priv_e                    tgt
);
    logic  pass_m;
    logic  pass_u;
    priv_e raw;

    always_comb begin
        pass_m = deleg_m[code];
        pass_u = has_s ? (pass_m & has_n & deleg_s[code]) : (pass_m & has_n);
        if (irq)
            raw = PRV_M;
        else if (has_u && pass_u)
            raw = PRV_U;
        else if (has_s && pass_m)
            raw = PRV_S;
        else
            raw = PRV_M;
        // never move to a less privileged level on a trap
        tgt = (logic'(raw < cur)) ? cur : raw;
    end
endmodule

// File: rtl/trap_status.sv
`timescale 1ns/1ps
module trap_status
    import trap_ctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  op_e   op,
    input  priv_e tgt,
    input  logic  has_u,
    output priv_e priv_q,
    output stat_t st_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            priv_q <= PRV_M;
            st_q   <= '0;
        end else begin
            case (op)
                OP_TRAP: begin
                    case (tgt)
                        PRV_M: begin
                            st_q.mpie <= st_q.mie;
                            st_q.mie  <= 1'b0;
                            st_q.mpp  <= priv_q;
                        end
                        PRV_S: begin
                            st_q.spie <= st_q.sie;
                            st_q.sie  <= 1'b0;
                            st_q.spp  <= (priv_q == PRV_S);
                        end
                        default: begin
                            st_q.upie <= st_q.uie;
                            st_q.uie  <= 1'b0;
                        end
                    endcase
                    priv_q <= tgt;
                end
                OP_MRET: begin
                    st_q.mie  <= st_q.mpie;
                    st_q.mpie <= 1'b1;
                    priv_q    <= st_q.mpp;
                    st_q.mpp  <= has_u ? PRV_U : PRV_M;
                end
                OP_SRET: begin
                    st_q.sie  <= st_q.spie;
                    st_q.spie <= 1'b1;
                    priv_q    <= st_q.spp ? PRV_S : PRV_U;
                    st_q.spp  <= 1'b0;
                end
                OP_URET: begin
                    st_q.uie  <= st_q.upie;
                    st_q.upie <= 1'b1;
                    priv_q    <= PRV_U;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/trap_csr_bank.sv
`timescale 1ns/1ps
module trap_csr_bank #(
    parameter int XLEN   = 32,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              irq,
    input  logic [CODE_W-1:0] code,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   val,
    input  logic              val_ok,
    output logic [XLEN-1:0]   epc_q,
    output logic [XLEN-1:0]   cause_q,
    output logic [XLEN-1:0]   tval_q
);
    localparam int PAD_W = XLEN - 1 - CODE_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            epc_q   <= '0;
            cause_q <= '0;
            tval_q  <= '0;
        end else if (wr_en) begin
            epc_q   <= pc;
            cause_q <= {irq, {PAD_W{1'b0}}, code};
            tval_q  <= val_ok ? val : '0;
        end
    end
endmodule

// File: rtl/trap_ctl_top.sv
`timescale 1ns/1ps
module trap_ctl_top
    import trap_ctl_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int CODE_W = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   trap_req,
    input  logic                   trap_irq,
    input  logic [CODE_W-1:0]      trap_code,
    input  logic [XLEN-1:0]        trap_pc,
    input  logic [XLEN-1:0]        trap_val,
    input  logic                   trap_val_ok,
    input  logic [(1<<CODE_W)-1:0] exc_deleg_m,
    input  logic [(1<<CODE_W)-1:0] exc_deleg_s,
    input  logic                   ret_m,
    input  logic                   ret_s,
    input  logic                   ret_u,
    input  logic                   has_s,
    input  logic                   has_u,
    input  logic                   has_n,
    output logic [1:0]             cur_priv,
    output logic [XLEN-1:0]        status,
    output logic [XLEN-1:0]        m_epc,
    output logic [XLEN-1:0]        m_cause,
    output logic [XLEN-1:0]        m_tval,
    output logic [XLEN-1:0]        s_epc,
    output logic [XLEN-1:0]        s_cause,
    output logic [XLEN-1:0]        s_tval,
    output logic [XLEN-1:0]        u_epc,
    output logic [XLEN-1:0]        u_cause,
    output logic [XLEN-1:0]        u_tval,
    output logic                   rsv_cancel,
    output logic                   vec_go,
    output logic [1:0]             vec_level
);
    localparam int NLVL = 3;

    op_e   op;
    priv_e tgt;
    priv_e priv_q;
    stat_t st_q;

    logic [XLEN-1:0] epc_a   [NLVL];
    logic [XLEN-1:0] cause_a [NLVL];
    logic [XLEN-1:0] tval_a  [NLVL];

    // trap first, then returns by privilege
    always_comb begin
        if (trap_req)   op = OP_TRAP;
        else if (ret_m) op = OP_MRET;
        else if (ret_s) op = OP_SRET;
        else if (ret_u) op = OP_URET;
        else            op = OP_NONE;
    end

    trap_deleg #(.CODE_W(CODE_W)) i_deleg (
        .irq     (trap_irq),
        .code    (trap_code),
        .deleg_m (exc_deleg_m),
        .deleg_s (exc_deleg_s),
        .has_s   (has_s),
        .has_u   (has_u),
        .has_n   (has_n),
        .cur     (priv_q),
        .tgt     (tgt)
    );

    trap_status i_status (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .tgt    (tgt),
        .has_u  (has_u),
        .priv_q (priv_q),
        .st_q   (st_q)
    );

    for (genvar g = 0; g < NLVL; g++) begin : g_lvl
        trap_csr_bank #(.XLEN(XLEN), .CODE_W(CODE_W)) i_bank (
            .clk     (clk),
            .rst     (rst),
            .wr_en   ((op == OP_TRAP) && (lvl_idx(tgt) == g)),
            .irq     (trap_irq),
            .code    (trap_code),
            .pc      (trap_pc),
            .val     (trap_val),
            .val_ok  (trap_val_ok),
            .epc_q   (epc_a[g]),
            .cause_q (cause_a[g]),
            .tval_q  (tval_a[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsv_cancel <= 1'b0;
            vec_go     <= 1'b0;
            vec_level  <= PRV_M;
        end else begin
            rsv_cancel <= (op != OP_NONE);
            vec_go     <= (op == OP_TRAP);
            if (op == OP_TRAP)
                vec_level <= tgt;
        end
    end

    assign cur_priv = priv_q;
    assign status   = {{(XLEN-ST_W){1'b0}}, pack_status(st_q)};
    assign u_epc    = epc_a[0];
    assign u_cause  = cause_a[0];
    assign u_tval   = tval_a[0];
    assign s_epc    = epc_a[1];
    assign s_cause  = cause_a[1];
    assign s_tval   = tval_a[1];
    assign m_epc    = epc_a[2];
    assign m_cause  = cause_a[2];
    assign m_tval   = tval_a[2];
endmodule

// File: rtl/trap_ctl_chk.sv
`timescale 1ns/1ps
module trap_ctl_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            trap_req,
    input logic            trap_irq,
    input logic [XLEN-1:0] trap_pc,
    input logic            ret_m,
    input logic            ret_s,
    input logic            ret_u,
    input logic            has_u,
    input logic [1:0]      cur_priv,
    input logic [XLEN-1:0] status,
    input logic [XLEN-1:0] m_epc,
    input logic            rsv_cancel,
    input logic            vec_go,
    input logic [1:0]      vec_level
);
    logic any_op;
    assign any_op = trap_req | ret_m | ret_s | ret_u;

    AST_PRIV_ENCODING: assert property (@(posedge clk) disable iff (rst)
        cur_priv != 2'b10);                                                  // R1
    AST_IRQ_TO_MACHINE: assert property (@(posedge clk) disable iff (rst)
        trap_req && trap_irq |=> vec_level == 2'b11);                        // R2
    AST_NO_LOWERING: assert property (@(posedge clk) disable iff (rst)
        trap_req |=> cur_priv >= $past(cur_priv));                           // R3
    AST_MACHINE_ENTRY: assert property (@(posedge clk) disable iff (rst)
        trap_req |=> (vec_level != 2'b11) || (!status[3] && m_epc == $past(trap_pc))); // R4
    AST_MRET_STACK: assert property (@(posedge clk) disable iff (rst)
        ret_m && !trap_req |=> status[7] && status[12:11] == ($past(has_u) ? 2'b00 : 2'b11)); // R7
    AST_SRET_STACK: assert property (@(posedge clk) disable iff (rst)
        ret_s && !trap_req && !ret_m |=> status[5] && !status[8]);           // R8
    AST_CANCEL_PULSE: assert property (@(posedge clk) disable iff (rst)
        any_op |=> rsv_cancel);                                              // R10
    AST_CANCEL_QUIET: assert property (@(posedge clk) disable iff (rst)
        !any_op |=> !rsv_cancel);                                            // R10
    AST_TRAP_WINS: assert property (@(posedge clk) disable iff (rst)
        trap_req && (ret_m || ret_s || ret_u) |=> vec_go);                  // R11
    AST_VEC_ONLY_TRAP: assert property (@(posedge clk) disable iff (rst)
        !trap_req |=> !vec_go);                                              // R12
endmodule

bind trap_ctl_top trap_ctl_chk #(.XLEN(XLEN)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .trap_req   (trap_req),
    .trap_irq   (trap_irq),
    .trap_pc    (trap_pc),
    .ret_m      (ret_m),
    .ret_s      (ret_s),
    .ret_u      (ret_u),
    .has_u      (has_u),
    .cur_priv   (cur_priv),
    .status     (status),
    .m_epc      (m_epc),
    .rsv_cancel (rsv_cancel),
    .vec_go     (vec_go),
    .vec_level  (vec_level)
);

// File: tb/test_trap_ctl_top.sv
`timescale 1ns/1ps
module test_trap_ctl_top;
    localparam int XLEN   = 32;
    localparam int CODE_W = 4;
    localparam int NC     = 1 << CODE_W;
    localparam int OPS    = 800;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic              trap_req = 0, trap_irq = 0, trap_val_ok = 0;
    logic [CODE_W-1:0] trap_code = '0;
    logic [XLEN-1:0]   trap_pc = '0, trap_val = '0;
    logic [NC-1:0]     exc_deleg_m = '0, exc_deleg_s = '0;
    logic              ret_m = 0, ret_s = 0, ret_u = 0;
    logic              has_s = 1, has_u = 1, has_n = 1;
    logic [1:0]        cur_priv, vec_level;
    logic [XLEN-1:0]   status, m_epc, m_cause, m_tval, s_epc, s_cause, s_tval, u_epc, u_cause, u_tval;
    logic              rsv_cancel, vec_go;

    trap_ctl_top #(.XLEN(XLEN), .CODE_W(CODE_W)) i_trap_ctl_top (
        .clk(clk), .rst(rst), .trap_req(trap_req), .trap_irq(trap_irq),
        .trap_code(trap_code), .trap_pc(trap_pc), .trap_val(trap_val),
        .trap_val_ok(trap_val_ok), .exc_deleg_m(exc_deleg_m), .exc_deleg_s(exc_deleg_s),
        .ret_m(ret_m), .ret_s(ret_s), .ret_u(ret_u),
        .has_s(has_s), .has_u(has_u), .has_n(has_n),
        .cur_priv(cur_priv), .status(status),
        .m_epc(m_epc), .m_cause(m_cause), .m_tval(m_tval),
        .s_epc(s_epc), .s_cause(s_cause), .s_tval(s_tval),
        .u_epc(u_epc), .u_cause(u_cause), .u_tval(u_tval),
        .rsv_cancel(rsv_cancel), .vec_go(vec_go), .vec_level(vec_level)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // reference state
    logic [1:0]      e_priv, e_mpp, e_lvl;
    logic            e_uie, e_sie, e_mie, e_upie, e_spie, e_mpie, e_spp;
    logic [XLEN-1:0] e_epc [3];
    logic [XLEN-1:0] e_cause [3];
    logic [XLEN-1:0] e_tval [3];
    logic            e_cancel, e_go;
    logic [31:0]     seed = 32'h1234_5678;

    function automatic logic [XLEN-1:0] e_status();
        logic [XLEN-1:0] v;
        v = '0;
        v[0] = e_uie; v[1] = e_sie; v[3] = e_mie; v[4] = e_upie;
        v[5] = e_spie; v[7] = e_mpie; v[8] = e_spp; v[12:11] = e_mpp;
        return v;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        e_priv = 2'b11; e_mpp = 2'b00; e_lvl = 2'b11;
        {e_uie, e_sie, e_mie, e_upie, e_spie, e_mpie, e_spp} = '0;
        for (int i = 0; i < 3; i++) begin
            e_epc[i] = '0; e_cause[i] = '0; e_tval[i] = '0;
        end
        e_cancel = 0; e_go = 0;
    endtask

    task automatic check_all(input string tag, input string reg_tag);
        check(tag,     "cur_priv",   {30'd0, cur_priv}, {30'd0, e_priv});
        check(tag,     "status",     status, e_status());
        check(reg_tag, "m_epc",      m_epc, e_epc[2]);
        check(reg_tag, "m_cause",    m_cause, e_cause[2]);
        check(reg_tag, "m_tval",     m_tval, e_tval[2]);
        check(reg_tag, "s_epc",      s_epc, e_epc[1]);
        check(reg_tag, "s_cause",    s_cause, e_cause[1]);
        check(reg_tag, "s_tval",     s_tval, e_tval[1]);
        check(reg_tag, "u_epc",      u_epc, e_epc[0]);
        check(reg_tag, "u_cause",    u_cause, e_cause[0]);
        check(reg_tag, "u_tval",     u_tval, e_tval[0]);
        check("R10",   "rsv_cancel", {31'd0, rsv_cancel}, {31'd0, e_cancel});
        check("R12",   "vec_go",     {31'd0, vec_go}, {31'd0, e_go});
        check("R12",   "vec_level",  {30'd0, vec_level}, {30'd0, e_lvl});
    endtask

    task automatic do_reset();
        rst = 1'b1;
        {trap_req, ret_m, ret_s, ret_u} = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
        check_all("R1", "R1");
    endtask

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    // one operation: drive at negedge, model, sample at next negedge
    task automatic step();
        logic [31:0] r;
        logic [2:0]  k;
        logic [1:0]  raw, tgt;
        logic        pm, pu;
        int          li;
        string       tag, rtag;
        r = rnd();
        k = r[2:0];
        trap_req    = (k >= 3'd1 && k <= 3'd4);
        trap_irq    = (k == 3'd4);
        ret_m       = (k == 3'd5) | (r[8] & r[9]) | (k == 3'd6 & r[10]);
        ret_s       = (k == 3'd6) | (r[11] & r[12]) | (k == 3'd7 & r[13]);
        ret_u       = (k == 3'd7) | (r[14] & r[15]);
        trap_code   = r[19:16];
        trap_val_ok = r[20];
        trap_pc     = rnd();
        trap_val    = rnd();
        r = rnd();
        exc_deleg_m = r[15:0];
        exc_deleg_s = r[31:16];

        tag = "R0"; rtag = "R0";
        e_cancel = trap_req | ret_m | ret_s | ret_u;
        e_go     = trap_req;
        if (trap_req) begin
            pm = exc_deleg_m[trap_code];
            pu = has_s ? (pm & has_n & exc_deleg_s[trap_code]) : (pm & has_n);
            if (trap_irq)          raw = 2'b11;
            else if (has_u && pu)  raw = 2'b00;
            else if (has_s && pm)  raw = 2'b01;
            else                   raw = 2'b11;
            tgt = (raw < e_priv) ? e_priv : raw;
            li  = (tgt == 2'b11) ? 2 : int'(tgt);
            e_epc[li]   = trap_pc;
            e_cause[li] = {trap_irq, {(XLEN-1-CODE_W){1'b0}}, trap_code};
            e_tval[li]  = trap_val_ok ? trap_val : '0;
            if (tgt == 2'b11) begin
                e_mpie = e_mie; e_mie = 0; e_mpp = e_priv; tag = "R4";
            end else if (tgt == 2'b01) begin
                e_spie = e_sie; e_sie = 0; e_spp = (e_priv == 2'b01); tag = "R5";
            end else begin
                e_upie = e_uie; e_uie = 0; tag = "R6";
            end
            rtag = tag;
            if (raw < e_priv) tag = "R3";
            else if (!trap_irq && raw != 2'b11) tag = "R2";
            if (ret_m | ret_s | ret_u) tag = "R11";
            e_priv = tgt;
            e_lvl  = tgt;
        end else if (ret_m) begin
            e_mie = e_mpie; e_mpie = 1; e_priv = e_mpp; e_mpp = has_u ? 2'b00 : 2'b11;
            tag = (ret_s | ret_u) ? "R11" : "R7"; rtag = "R7";
        end else if (ret_s) begin
            e_sie = e_spie; e_spie = 1; e_priv = e_spp ? 2'b01 : 2'b00; e_spp = 0;
            tag = ret_u ? "R11" : "R8"; rtag = "R8";
        end else if (ret_u) begin
            e_uie = e_upie; e_upie = 1; e_priv = 2'b00;
            tag = "R9"; rtag = "R9";
        end else begin
            tag = "R10"; rtag = "R10";
        end
        @(negedge clk);
        check_all(tag, rtag);
    endtask

    initial begin
        @(negedge clk);
        for (int c = 0; c < 8; c++) begin
            has_s = c[2]; has_u = c[1]; has_n = c[0];
            if (has_s && !has_u) continue;
            do_reset();
            for (int n = 0; n < OPS; n++) step();
        end
        {trap_req, ret_m, ret_s, ret_u} = '0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule